// File: doc/BRIEF.md
# Dual-Word Numerically Controlled Oscillator

This block is a direct digital synthesis core. Two 32-bit tuning words sit in the block, and a select input picks which one is added to a 32-bit phase accumulator on every clock. Moving between the two words takes one clock, which makes binary frequency-shift keying a matter of toggling one pin. A 2-bit phase modulation input is added to the top of the phase, which gives quadrature phase-shift keying in 90-degree steps. The 13 upper phase bits drive a sine lookup whose 12-bit sample is offset binary and can go straight to a DAC.

The tuning words arrive over a slow serial link. The link has a data line, a shift clock, a shift enable and a bit-order choice. One extra frame bit names the word register that will receive the frame. A one-cycle transfer strobe then copies the shifted frame into that register, so the word that is currently generating the tone is never disturbed while the other word is being prepared. Every path from a control input to the sample takes the same six clock registers.

Top module: `dds_dual_word_osc`

## Requirements
- R1: Once reset has been released, both tuning words and the accumulator are zero and `sample` reads 0x800 (mid-scale, zero amplitude). With a zero word the sample stays constant.
- R2: A serial frame is 33 bits long. On each rising edge of `ser_clk` while `ser_en` is high, one bit of `ser_data` is shifted in. When `msb_first`=1 the frame is sent as the target bit first, then word bits 31 down to 0. When `msb_first`=0 the frame is sent as word bits 0 up to 31, then the target bit. Edges of `ser_clk` while `ser_en` is low leave the frame untouched.
- R3: A high `xfer` for one cycle copies the frame's 32 word bits into word A (target bit 0) or word B (target bit 1). The other word is not changed. Without `xfer`, neither word changes.
- R4: `word_sel`=0 selects word A and `word_sel`=1 selects word B. The selected word is added to the accumulator (modulo 2^32) once per clock, and a change of select takes effect on the next add.
- R5: While `acc_en` is low, the accumulator holds its value.
- R6: The 13-bit lookup phase is accumulator bits [31:19] plus `phase_mod`·2048, modulo 8192. `phase_mod` values 0..3 give 0, 90, 180 and 270 degrees.
- R7: For a lookup phase p, `sample` lies within ±1 of 2047.5 + 2047.5·sin(2π(p+0.5)/8192).
- R8: Two phases that differ by 180 degrees give samples that sum to exactly 4095. Phases in the lower half give samples of 0x800 or more, and phases in the upper half give samples below 0x800.
- R9: A value of `word_sel`, `acc_en` or `phase_mod` that is sampled at clock edge k first affects `sample` just after edge k+5. This is six registers, and the count does not vary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial frame data |
| ser_en | input | 1 | Shift enable for the serial frame |
| msb_first | input | 1 | Frame bit order: 1 = target bit then MSB first, 0 = LSB first then target bit |
| xfer | input | 1 | Transfer strobe: writes the frame into the target word |
| word_sel | input | 1 | Tuning word select: 0 = A, 1 = B |
| acc_en | input | 1 | Phase accumulation enable |
| phase_mod | input | 2 | Quadrature phase offset in 90-degree steps |
| sample | output | 12 | Offset-binary sine sample |

## Verification
The assertions assume that `ser_clk` is slow next to `clk`. Each of its levels must last at least two core clocks, and `ser_data`, `ser_en` and `msb_first` must stay steady around each rising edge once that edge has passed the synchronizer. The assertions also assume that reset is held long enough for the two-stage reset synchronizer to clear. The stimulus holds every serial level for several clocks and changes the data only while `ser_clk` is low. All direct inputs are driven half a cycle away from the sampling edge. Random traffic covers word select, phase offsets, accumulation enable and word loads in both bit orders, including loads into the word that is not selected.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Which tuning word register a serial frame targets
  typedef enum logic {
    TGT_WORD_A = 1'b0,
    TGT_WORD_B = 1'b1
  } word_tgt_e;

  localparam int NUM_WORDS = 2;
endpackage

// File: rtl/nco_serial_load.sv
module nco_serial_load #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         ser_en,
  input  logic         msb_first,
  input  logic         xfer,
  output logic [W-1:0] word_a,
  output logic [W-1:0] word_b
);
  import nco_pkg::*;

  localparam int FW = W + 1;  // frame: word bits plus target bit on top

  logic          sclk_m, sclk_s, sclk_d;
  logic          shift_edge;
  logic [FW-1:0] frame_q, frame_nxt;
  logic          frame_tgt;

  // Bring the slow serial clock into the core domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 1'b0;
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sclk_m <= ser_clk;
      sclk_s <= sclk_m;
      sclk_d <= sclk_s;
    end
  end

  assign shift_edge = sclk_s & ~sclk_d;

  always_comb begin
    frame_nxt = frame_q;
    if (shift_edge && ser_en) begin
      if (msb_first) frame_nxt = {frame_q[FW-2:0], ser_data};
      else           frame_nxt = {ser_data, frame_q[FW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_nxt;
  end

  assign frame_tgt = frame_q[FW-1];

  // One register per tuning word, each with its own write enable
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gen_word
    logic [W-1:0] q_word;
    logic         wr_en;
    assign wr_en = xfer && (frame_tgt == g[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_word <= '0;
      else if (wr_en) q_word <= frame_q[W-1:0];
    end
  end

  assign word_a = gen_word[0].q_word;
  assign word_b = gen_word[1].q_word;

  // R2: no shift unless an enabled serial edge was seen
  a_r2_shift_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_edge && ser_en) |=> $stable(frame_q));

  // R3: words move only on a transfer strobe
  a_r3_hold_without_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(word_a) && $stable(word_b)));

  // R3: a transfer to one word leaves the other alone
  a_r3_a_spared: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_tgt == TGT_WORD_B) |=> $stable(word_a));

  a_r3_b_spared: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && frame_tgt == TGT_WORD_A) |=> $stable(word_b));
endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
  parameter int W  = 32,
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_b,
  input  logic          word_sel,
  input  logic          acc_en,
  input  logic [1:0]    phase_mod,
  output logic [PW-1:0] phase
);
  localparam int LOW_ZEROS = PW - 2;

  // stage 1: capture controls
  logic [W-1:0]  inc_q, inc_nxt;
  logic          en_q;
  logic [1:0]    off1_q;
  // stage 2: accumulator
  logic [W-1:0]  acc_q, acc_nxt;
  logic [1:0]    off2_q;
  // stage 3: offset phase
  logic [PW-1:0] ph_q, ph_nxt;

  always_comb begin
    inc_nxt = word_sel ? word_b : word_a;
    acc_nxt = en_q ? (acc_q + inc_q) : acc_q;
    ph_nxt  = acc_q[W-1 -: PW] + {off2_q, {LOW_ZEROS{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q  <= '0;
      en_q   <= 1'b0;
      off1_q <= '0;
      acc_q  <= '0;
      off2_q <= '0;
      ph_q   <= '0;
    end else begin
      inc_q  <= inc_nxt;
      en_q   <= acc_en;
      off1_q <= phase_mod;
      acc_q  <= acc_nxt;
      off2_q <= off1_q;
      ph_q   <= ph_nxt;
    end
  end

  assign phase = ph_q;

  // R5: accumulator frozen while the registered enable is low
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(acc_q));

  // R4: a zero increment never moves the accumulator
  a_r4_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0) |=> $stable(acc_q));
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PW = 13,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  output logic [OW-1:0] sample
);
  localparam int  IW     = PW - 2;        // quarter-wave index width
  localparam int  QDEPTH = 1 << IW;
  localparam int  MW     = OW - 1;        // magnitude width
  localparam real AMP    = real'(1 << MW) - 0.5;
  localparam real HALF_PI = 1.5707963267948966;
  localparam logic [OW-1:0] MID = {1'b1, {MW{1'b0}}};

  typedef logic [MW-1:0] qtab_t [QDEPTH];

  function automatic qtab_t build_qtab();
    qtab_t t;
    real   ang;
    for (int i = 0; i < QDEPTH; i++) begin
      ang  = HALF_PI * (real'(i) + 0.5) / real'(QDEPTH);
      t[i] = MW'($rtoi($floor(AMP * $sin(ang))));
    end
    return t;
  endfunction

  localparam qtab_t QTAB = build_qtab();

  logic [IW-1:0] idx_q, idx_nxt;
  logic          neg4_q, neg5_q;
  logic [MW-1:0] mag_q;
  logic [OW-1:0] out_q, out_nxt;

  always_comb begin
    // odd quadrants read the table backwards, upper half is negated
    idx_nxt = phase[IW-1:0] ^ {IW{phase[PW-2]}};
    out_nxt = neg5_q ? ({1'b0, {MW{1'b1}}} - {1'b0, mag_q})
                     : (MID + {1'b0, mag_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      neg4_q <= 1'b0;
      mag_q  <= '0;
      neg5_q <= 1'b0;
      out_q  <= MID;
    end else begin
      idx_q  <= idx_nxt;
      neg4_q <= phase[PW-1];
      mag_q  <= QTAB[idx_q];
      neg5_q <= neg4_q;
      out_q  <= out_nxt;
    end
  end

  assign sample = out_q;

  // R8: sign of the sample follows the half of the cycle
  a_r8_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    !neg5_q |=> sample[OW-1]);

  a_r8_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    neg5_q |=> !sample[OW-1]);
endmodule

// File: rtl/dds_dual_word_osc.sv
module dds_dual_word_osc #(
  parameter int W  = 32,
  parameter int PW = 13,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_data,
  input  logic          ser_en,
  input  logic          msb_first,
  input  logic          xfer,
  input  logic          word_sel,
  input  logic          acc_en,
  input  logic [1:0]    phase_mod,
  output logic [OW-1:0] sample
);
  logic          rst_m, rst_sync;
  logic [W-1:0]  word_a, word_b;
  logic [PW-1:0] phase;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m    <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_m    <= 1'b1;
      rst_sync <= rst_m;
    end
  end

  nco_serial_load #(.W(W)) u_load (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_en    (ser_en),
    .msb_first (msb_first),
    .xfer      (xfer),
    .word_a    (word_a),
    .word_b    (word_b)
  );

  nco_phase_path #(.W(W), .PW(PW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_sync),
    .word_a    (word_a),
    .word_b    (word_b),
    .word_sel  (word_sel),
    .acc_en    (acc_en),
    .phase_mod (phase_mod),
    .phase     (phase)
  );

  nco_sine_lut #(.PW(PW), .OW(OW)) u_sine (
    .clk    (clk),
    .rst_n  (rst_sync),
    .phase  (phase),
    .sample (sample)
  );

  // R1: while held in reset the sample is mid-scale
  a_r1_reset_mid: assert property (@(posedge clk)
    !rst_sync |=> (sample == {1'b1, {(OW-1){1'b0}}}));
endmodule

// File: tb/tb_dds_dual_word_osc.sv
module tb_dds_dual_word_osc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_data, ser_en, msb_first, xfer;
  logic        word_sel, acc_en;
  logic [1:0]  phase_mod;
  logic [11:0] sample;

  int errs = 0;
  int checks = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // pending transfer, written into the model at the strobe edge
  logic        pend_tgt;
  logic [31:0] pend_word;

  // reference pipeline built from R4, R6 and R9
  logic [31:0] mwa, mwb, m_inc, m_acc;
  logic        m_en;
  logic [1:0]  m_o1, m_o2;
  logic [12:0] m_ph, m_ph4, m_ph5, m_ph6;

  always #5 clk = ~clk;

  dds_dual_word_osc dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .msb_first(msb_first), .xfer(xfer),
    .word_sel(word_sel), .acc_en(acc_en), .phase_mod(phase_mod),
    .sample(sample)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mwa <= '0; mwb <= '0; m_inc <= '0; m_acc <= '0; m_en <= 1'b0;
      m_o1 <= '0; m_o2 <= '0; m_ph <= '0; m_ph4 <= '0; m_ph5 <= '0; m_ph6 <= '0;
    end else begin
      if (xfer) begin
        if (pend_tgt) mwb <= pend_word;
        else          mwa <= pend_word;
      end
      m_inc <= word_sel ? mwb : mwa;
      m_en  <= acc_en;
      m_o1  <= phase_mod;
      if (m_en) m_acc <= m_acc + m_inc;
      m_o2  <= m_o1;
      m_ph  <= m_acc[31:19] + {m_o2, 11'b0};
      m_ph4 <= m_ph;
      m_ph5 <= m_ph4;
      m_ph6 <= m_ph5;
    end
  end

  function automatic real ideal(input logic [12:0] p);
    return 2047.5 + 2047.5 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 8192.0);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // R7 with R4/R6/R9 timing: every sample within one code of the model
  always @(negedge clk) begin
    if (mon_on) begin
      real e, d;
      e = ideal(m_ph6);
      d = real'(sample) - e;
      checks++;
      if (d > 1.0 || d < -1.0) begin
        errs++;
        $display("FAIL R7/R9: got %0d expected %0d (phase %0d)", sample, $rtoi(e + 0.5), m_ph6);
      end
    end
  end

  task automatic send_bit(input logic b);
    ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // R2: frame in either order, then optional R3 transfer
  task automatic shift_frame(input logic tgt, input logic [31:0] w, input logic msb);
    msb_first = msb;
    ser_en = 1'b1;
    if (msb) begin
      send_bit(tgt);
      for (int i = 31; i >= 0; i--) send_bit(w[i]);
    end else begin
      for (int i = 0; i < 32; i++) send_bit(w[i]);
      send_bit(tgt);
    end
    ser_en = 1'b0;
  endtask

  task automatic strobe(input logic tgt, input logic [31:0] w);
    pend_tgt = tgt;
    pend_word = w;
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 15) == 0) word_sel = ~word_sel;
      if ($urandom_range(0, 7) == 0)  phase_mod = 2'($urandom_range(0, 3));
      acc_en = ($urandom_range(0, 9) != 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int v0;
    logic [31:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0;
    msb_first = 1'b1; xfer = 1'b0; word_sel = 1'b0; acc_en = 1'b0;
    phase_mod = 2'd0; pend_tgt = 1'b0; pend_word = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: mid-scale after reset, constant with zero words and accumulation on
    check_eq("R1 reset sample", int'(sample), 32'h800);
    acc_en = 1'b1;
    repeat (20) @(negedge clk);
    check_eq("R1 zero word constant", int'(sample), 32'h800);
    mon_on = 1'b1;

    // R2/R3: word A MSB-first, word B LSB-first
    shift_frame(1'b0, 32'h0123_4567, 1'b1);
    strobe(1'b0, 32'h0123_4567);
    run_random(300);
    shift_frame(1'b1, 32'h0800_0000, 1'b0);
    strobe(1'b1, 32'h0800_0000);
    run_random(300);

    // R2: edges with shift disabled leave the pending frame intact
    word_sel = 1'b1;
    shift_frame(1'b0, 32'h0F00_0000, 1'b1);
    msb_first = 1'b1;
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    strobe(1'b0, 32'h0F00_0000);
    word_sel = 1'b0;
    run_random(300);

    // R3: reload the unselected word while the selected one runs
    for (int k = 0; k < 6; k++) begin
      logic t;
      logic m;
      w = $urandom();
      t = k[0];
      m = 1'($urandom_range(0, 1));
      word_sel = ~t;
      shift_frame(t, w, m);
      strobe(t, w);
      run_random(250);
    end

    // R5/R6/R8/R9: freeze phase, step offsets by 180 degrees
    for (int k = 0; k < 4; k++) begin
      acc_en = 1'b0;
      phase_mod = 2'(k);
      repeat (10) @(negedge clk);
      v0 = int'(sample);
      check_eq("R5 frozen accumulator", int'(sample), v0);
      phase_mod = 2'(k + 2);
      for (int c = 1; c <= 5; c++) begin
        @(negedge clk);
        check_eq("R9 output held during latency", int'(sample), v0);
      end
      @(negedge clk);
      check_eq("R8/R9 half-cycle step after six clocks", int'(sample), 4095 - v0);
      phase_mod = 2'(k + 1);
      repeat (10) @(negedge clk);
      acc_en = 1'b1;
      run_random(200);
    end

    run_random(2000);
    mon_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule